// File: doc/BRIEF.md
# USB Low/Full-Speed Line-State Classifier

This block sits right after the D+ and D- receivers of a low-speed/full-speed USB port. It runs on an oversampling clock. It first resynchronizes both wires, then names every sample as one of four bus symbols: J, K, single-ended zero (SE0) or single-ended one (SE1). Whether J or K is meant depends on the active speed, because the two speeds use opposite idle polarity. The block also keeps the active speed itself. It learns the speed from the idle polarity when it is configured for automatic mode. When a downstream framer reports a low-speed preamble, it switches to a mode that runs at the low-speed rate but keeps full-speed polarity.

Outside packets, the block times each SE0 stretch. A long stretch is reported as a bus reset and returns the speed to its configured setting. A medium stretch is reported as a low-speed keep-alive, but only while the port runs at plain low speed. A NRZI decoder can read the last differential symbol from the block as its reference. That symbol is forced back to J whenever the bus returns to idle.

Top module: `usb_line_state`

## Requirements
- R1: `sym_o` uses J=0, K=1, SE0=2, SE1=3. Both wires low give SE0 and both wires high give SE1 at any speed. `sym_o` reflects the wire levels sampled SYNC_STAGES+1 clock edges earlier (3 with defaults).
- R2: At full speed (`speed_o`=0), D+ high with D- low is J, and D+ low with D- high is K.
- R3: At low speed (`speed_o`=1), the polarity is swapped: D+ high with D- low is K, and D+ low with D- high is J.
- R4: In the low-rate mode with full-speed polarity (`speed_o`=2), J and K are mapped as in R2.
- R5: `mode_cfg_i` selects 0=automatic, 1=full, 2=low, 3=low rate with full polarity. While `rst` is high: `speed_o` is the configured speed (automatic gives full), `sym_o` and `last_sym_o` are J, and both pulses are low.
- R6: Idle detection happens outside a packet (`pkt_active_i` low) on the first differential sample after reset or after an SE0. In automatic mode it selects full speed if D+ is high and low speed if D- is high. In any fixed mode it restores the configured speed. The new speed applies to that same sample.
- R7: An SE0 outside a packet that lasts more than RST_CYC samples gives a one-cycle `bus_reset_o` on the first non-SE0 sample. The speed then reverts to the configured setting, or is re-detected per R6 if that sample is differential.
- R8: An SE0 outside a packet that lasts more than KA_CYC and at most RST_CYC samples gives a one-cycle `keep_alive_o`, but only if `speed_o` was 1. It never coincides with `bus_reset_o`.
- R9: SE0 samples taken while `pkt_active_i` is high are not timed and produce no pulse.
- R10: A high `pre_seen_i` sets `speed_o` to 2 at the next edge. This mode holds until idle detection or a bus reset. A bus reset on the same edge takes priority.
- R11: `last_sym_o` holds the most recent J or K output. It becomes J on an idle detection, a bus reset or a preamble, unless a J/K sample on that same edge overrides it; it never takes an SE0 or SE1 value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| dp_i | input | 1 | Raw D+ level |
| dm_i | input | 1 | Raw D- level |
| mode_cfg_i | input | 2 | Configured speed mode (R5 encoding) |
| pkt_active_i | input | 1 | High while the framer is inside a packet |
| pre_seen_i | input | 1 | One-cycle preamble indication from the framer |
| sym_o | output | 2 | Current bus symbol |
| speed_o | output | 2 | Active speed: 0 full, 1 low, 2 low rate with full polarity |
| last_sym_o | output | 2 | Last differential symbol, J after idle |
| bus_reset_o | output | 1 | One-cycle bus reset pulse |
| keep_alive_o | output | 1 | One-cycle low-speed keep-alive pulse |

## Verification
All results that come from the wires (`sym_o`, `last_sym_o`, both pulses, and a speed learned at idle) appear three edges after the raw levels are driven: two synchronizer flops plus the output register. A preamble, the packet flag and the mode setting act on the very next edge. The bench drives inputs on falling edges and advances a reference model on each rising edge. That model keeps its own three-deep history of the raw wires. All five outputs are compared with it on the following falling edge, so every check lands in the cycle the result is due. SE0 lengths are placed one sample on each side of both thresholds to pin down the strict comparisons.

// File: rtl/usb_lsc_pkg.sv
package usb_lsc_pkg;

    typedef enum logic [1:0] {
        SYM_J   = 2'd0,
        SYM_K   = 2'd1,
        SYM_SE0 = 2'd2,
        SYM_SE1 = 2'd3
    } sym_e;

    typedef enum logic [1:0] {
        SPD_FS   = 2'd0,
        SPD_LS   = 2'd1,
        SPD_LSFP = 2'd2
    } spd_e;

    typedef enum logic [1:0] {
        CFG_AUTO = 2'd0,
        CFG_FS   = 2'd1,
        CFG_LS   = 2'd2,
        CFG_LSFP = 2'd3
    } cfg_e;

    typedef struct packed {
        logic dp;
        logic dm;
    } line_t;

    function automatic logic line_is_se0(line_t l);
        return !l.dp && !l.dm;
    endfunction

    function automatic logic line_is_diff(line_t l);
        return l.dp ^ l.dm;
    endfunction

    // Only plain low speed uses the inverted polarity.
    function automatic sym_e classify(line_t l, spd_e s);
        sym_e r;
        unique case ({l.dp, l.dm})
            2'b00:   r = SYM_SE0;
            2'b11:   r = SYM_SE1;
            2'b10:   r = (s == SPD_LS) ? SYM_K : SYM_J;
            default: r = (s == SPD_LS) ? SYM_J : SYM_K;
        endcase
        return r;
    endfunction

    function automatic spd_e base_speed(cfg_e c);
        spd_e r;
        unique case (c)
            CFG_LS:   r = SPD_LS;
            CFG_LSFP: r = SPD_LSFP;
            default:  r = SPD_FS;
        endcase
        return r;
    endfunction

    function automatic spd_e pick_speed(cfg_e c, line_t l);
        spd_e r;
        if (c == CFG_AUTO) r = l.dp ? SPD_FS : SPD_LS;
        else               r = base_speed(c);
        return r;
    endfunction

endpackage

// File: rtl/usb_lsc_sync.sv
module usb_lsc_sync #(
    parameter int              WIDTH   = 2,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) stg <= RST_VAL;
                else     stg <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) stg <= {STAGES{RST_VAL}};
                else     stg <= {stg[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/usb_lsc_se0_timer.sv
module usb_lsc_se0_timer #(
    parameter int RST_CYC = 120,
    parameter int KA_CYC  = 58
) (
    input  logic clk,
    input  logic rst,
    input  logic se0,
    input  logic pkt,
    input  logic spd_is_ls,
    output logic rst_now,
    output logic rst_pulse,
    output logic ka_pulse
);
    localparam int SAT = RST_CYC + 1;
    localparam int CW  = $clog2(SAT + 1);

    logic [CW-1:0] cnt;
    logic          ended;
    logic          over_rst;
    logic          over_ka;
    logic          ka_now;

    assign ended    = !se0 && !pkt && (cnt != '0);
    assign over_rst = cnt > CW'(RST_CYC);
    assign over_ka  = cnt > CW'(KA_CYC);
    assign rst_now  = ended && over_rst;
    assign ka_now   = ended && !over_rst && over_ka && spd_is_ls;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            rst_pulse <= 1'b0;
            ka_pulse  <= 1'b0;
        end else begin
            if (se0 && !pkt) begin
                if (cnt != CW'(SAT)) cnt <= cnt + 1'b1;
            end else begin
                cnt <= '0;
            end
            rst_pulse <= rst_now;
            ka_pulse  <= ka_now;
        end
    end
endmodule

// File: rtl/usb_lsc_speed.sv
module usb_lsc_speed
    import usb_lsc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  line_t line,
    input  logic  pkt,
    input  logic  pre,
    input  cfg_e  cfg,
    input  logic  rst_now,
    output spd_e  spd_q,
    output spd_e  spd_nxt,
    output logic  idle_now
);
    logic prev_se0;

    assign idle_now = !pkt && line_is_diff(line) && prev_se0;

    always_comb begin
        spd_nxt = spd_q;
        if (rst_now)       spd_nxt = line_is_diff(line) ? pick_speed(cfg, line) : base_speed(cfg);
        else if (pre)      spd_nxt = SPD_LSFP;
        else if (idle_now) spd_nxt = pick_speed(cfg, line);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            spd_q    <= base_speed(cfg);
            prev_se0 <= 1'b1;
        end else begin
            spd_q    <= spd_nxt;
            prev_se0 <= line_is_se0(line);
        end
    end
endmodule

// File: rtl/usb_line_state.sv
module usb_line_state
    import usb_lsc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int RST_CYC     = 120,
    parameter int KA_CYC      = 58
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       dp_i,
    input  logic       dm_i,
    input  logic [1:0] mode_cfg_i,
    input  logic       pkt_active_i,
    input  logic       pre_seen_i,
    output logic [1:0] sym_o,
    output logic [1:0] speed_o,
    output logic [1:0] last_sym_o,
    output logic       bus_reset_o,
    output logic       keep_alive_o
);
    logic [1:0] sync_q;
    line_t      line;
    spd_e       spd_q;
    spd_e       spd_nxt;
    logic       idle_now;
    logic       rst_now;
    sym_e       sym_d;
    sym_e       sym_q;
    sym_e       last_d;
    sym_e       last_q;

    // Reset value is SE0 so the first real idle sample triggers detection.
    usb_lsc_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES),
        .RST_VAL(2'b00)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  ({dp_i, dm_i}),
        .q  (sync_q)
    );

    assign line = line_t'(sync_q);

    usb_lsc_se0_timer #(
        .RST_CYC(RST_CYC),
        .KA_CYC (KA_CYC)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .se0      (line_is_se0(line)),
        .pkt      (pkt_active_i),
        .spd_is_ls(spd_q == SPD_LS),
        .rst_now  (rst_now),
        .rst_pulse(bus_reset_o),
        .ka_pulse (keep_alive_o)
    );

    usb_lsc_speed u_speed (
        .clk     (clk),
        .rst     (rst),
        .line    (line),
        .pkt     (pkt_active_i),
        .pre     (pre_seen_i),
        .cfg     (cfg_e'(mode_cfg_i)),
        .rst_now (rst_now),
        .spd_q   (spd_q),
        .spd_nxt (spd_nxt),
        .idle_now(idle_now)
    );

    assign sym_d = classify(line, spd_nxt);

    always_comb begin
        last_d = last_q;
        if (sym_d == SYM_J || sym_d == SYM_K)          last_d = sym_d;
        else if (rst_now || idle_now || pre_seen_i)    last_d = SYM_J;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sym_q  <= SYM_J;
            last_q <= SYM_J;
        end else begin
            sym_q  <= sym_d;
            last_q <= last_d;
        end
    end

    assign sym_o      = sym_q;
    assign last_sym_o = last_q;
    assign speed_o    = spd_q;
endmodule

// File: rtl/usb_line_state_chk.sv
module usb_line_state_chk (
    input logic       clk,
    input logic       rst,
    input logic       dp_i,
    input logic       dm_i,
    input logic       pkt_active_i,
    input logic       pre_seen_i,
    input logic [1:0] sym_o,
    input logic [1:0] speed_o,
    input logic       bus_reset_o,
    input logic       keep_alive_o
);
    logic [1:0] cyc;

    always_ff @(posedge clk) begin
        if (rst)              cyc <= 2'd0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end

    // R1: SE0 output traces back to both wires low three edges earlier
    a_r1_se0_map: assert property (@(posedge clk) disable iff (rst)
        (cyc == 2'd3 && sym_o == 2'd2) |-> (!$past(dp_i, 3) && !$past(dm_i, 3)));

    // R1: SE1 output traces back to both wires high
    a_r1_se1_map: assert property (@(posedge clk) disable iff (rst)
        (cyc == 2'd3 && sym_o == 2'd3) |-> ($past(dp_i, 3) && $past(dm_i, 3)));

    // R7: a bus reset pulse lasts one cycle
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        bus_reset_o |=> !bus_reset_o);

    // R8: keep-alive only while plain low speed was active
    a_r8_ka_only_ls: assert property (@(posedge clk) disable iff (rst)
        keep_alive_o |-> ($past(speed_o) == 2'd1));

    // R8: never both pulses at once
    a_r8_not_both: assert property (@(posedge clk) disable iff (rst)
        !(keep_alive_o && bus_reset_o));

    // R9: no pulse produced from a sample taken inside a packet
    a_r9_quiet_in_pkt: assert property (@(posedge clk) disable iff (rst)
        (keep_alive_o || bus_reset_o) |-> !$past(pkt_active_i));

    // R10: preamble selects low rate with full polarity unless a reset wins
    a_r10_pre_sets_mode: assert property (@(posedge clk) disable iff (rst)
        pre_seen_i |=> (speed_o == 2'd2 || bus_reset_o));
endmodule

bind usb_line_state usb_line_state_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .dp_i        (dp_i),
    .dm_i        (dm_i),
    .pkt_active_i(pkt_active_i),
    .pre_seen_i  (pre_seen_i),
    .sym_o       (sym_o),
    .speed_o     (speed_o),
    .bus_reset_o (bus_reset_o),
    .keep_alive_o(keep_alive_o)
);

// File: tb/usb_line_state_bench.sv
module usb_line_state_bench;
    localparam int RST_C = 120;
    localparam int KA_C  = 58;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dp = 1'b1;
    logic       dm = 1'b0;
    logic [1:0] cfg = 2'd0;
    logic       pkt = 1'b0;
    logic       pre = 1'b0;
    logic [1:0] sym_o;
    logic [1:0] speed_o;
    logic [1:0] last_sym_o;
    logic       bus_reset_o;
    logic       keep_alive_o;

    int checks = 0;
    int fails  = 0;
    bit run    = 1'b0;

    always #2 clk = ~clk;

    usb_line_state #(
        .SYNC_STAGES(2),
        .RST_CYC    (RST_C),
        .KA_CYC     (KA_C)
    ) u_usb_line_state (
        .clk         (clk),
        .rst         (rst),
        .dp_i        (dp),
        .dm_i        (dm),
        .mode_cfg_i  (cfg),
        .pkt_active_i(pkt),
        .pre_seen_i  (pre),
        .sym_o       (sym_o),
        .speed_o     (speed_o),
        .last_sym_o  (last_sym_o),
        .bus_reset_o (bus_reset_o),
        .keep_alive_o(keep_alive_o)
    );

    // ---------------- reference model from the requirements ----------------
    function automatic int cfg_base(int c);
        if (c == 2) return 1;
        if (c == 3) return 2;
        return 0;
    endfunction

    function automatic int exp_symbol(logic [1:0] w, int spd);
        if (w == 2'b00) return 2;
        if (w == 2'b11) return 3;
        if (w == 2'b10) return (spd == 1) ? 1 : 0;
        return (spd == 1) ? 0 : 1;
    endfunction

    logic [1:0] m_p1, m_p2;
    int m_cnt, m_spd, m_sym, m_last;
    bit m_prev_se0, m_rp, m_ka, m_pre, m_pkt;

    always @(posedge clk) begin
        if (rst) begin
            m_p1 = 2'b00; m_p2 = 2'b00; m_cnt = 0; m_prev_se0 = 1'b1;
            m_spd = cfg_base(int'(cfg)); m_sym = 0; m_last = 0;
            m_rp = 1'b0; m_ka = 1'b0; m_pre = 1'b0; m_pkt = 1'b0;
        end else begin
            bit se0, diff, ended, idle;
            int pick, nspd;
            se0   = (m_p2 == 2'b00);
            diff  = m_p2[1] ^ m_p2[0];
            ended = !se0 && !pkt && m_cnt > 0;
            m_rp  = ended && m_cnt > RST_C;
            m_ka  = ended && m_cnt <= RST_C && m_cnt > KA_C && m_spd == 1;
            idle  = !pkt && diff && m_prev_se0;
            pick  = (cfg == 2'd0) ? (m_p2[1] ? 0 : 1) : cfg_base(int'(cfg));
            nspd  = m_spd;
            if (m_rp)      nspd = diff ? pick : cfg_base(int'(cfg));
            else if (pre)  nspd = 2;
            else if (idle) nspd = pick;
            m_cnt      = (se0 && !pkt) ? m_cnt + 1 : 0;
            m_prev_se0 = se0;
            m_spd      = nspd;
            m_sym      = exp_symbol(m_p2, m_spd);
            if (m_sym < 2)                m_last = m_sym;
            else if (m_rp || idle || pre) m_last = 0;
            m_pre = pre;
            m_pkt = pkt;
            m_p2  = m_p1;
            m_p1  = {dp, dm};
        end
    end

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (run && !rst) begin
            string st;
            if (m_sym >= 2)      st = "R1";
            else if (m_spd == 0) st = "R2";
            else if (m_spd == 1) st = "R3";
            else                 st = "R4";
            chk(st, "sym_o", int'(sym_o), m_sym);
            chk(m_pre ? "R10" : "R6", "speed_o", int'(speed_o), m_spd);
            chk(m_pkt ? "R9" : "R7", "bus_reset_o", int'(bus_reset_o), int'(m_rp));
            chk(m_pkt ? "R9" : "R8", "keep_alive_o", int'(keep_alive_o), int'(m_ka));
            chk("R11", "last_sym_o", int'(last_sym_o), m_last);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic drv(input logic a, input logic b, input int n);
        repeat (n) begin
            @(negedge clk);
            dp = a;
            dm = b;
        end
    endtask

    task automatic pulse_pre();
        @(negedge clk); pre = 1'b1;
        @(negedge clk); pre = 1'b0;
    endtask

    // idle level for a speed: full speed idles D+ high, low speed D- high
    task automatic idle_for(input bit ls, input int n);
        if (ls) drv(1'b0, 1'b1, n);
        else    drv(1'b1, 1'b0, n);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        // R5: reset state with a fixed low-speed setting
        cfg = 2'd2;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R5", "reset speed_o", int'(speed_o), 1);
        chk("R5", "reset sym_o", int'(sym_o), 0);
        chk("R5", "reset last_sym_o", int'(last_sym_o), 0);
        chk("R5", "reset bus_reset_o", int'(bus_reset_o), 0);
        chk("R5", "reset keep_alive_o", int'(keep_alive_o), 0);
        cfg = 2'd0;
        @(negedge clk);
        chk("R5", "reset auto speed_o", int'(speed_o), 0);
        rst = 1'b0;
        run = 1'b1;

        // R6/R2: automatic learns full speed from D+ idle, then J/K/SE1
        idle_for(1'b0, 10);
        drv(1'b0, 1'b1, 3); drv(1'b1, 0, 2); drv(1'b1, 1'b1, 2); idle_for(1'b0, 4);
        // R8: keep-alive length at full speed gives nothing
        drv(1'b0, 1'b0, KA_C + 5); idle_for(1'b0, 6);
        // R7: reset threshold edges
        drv(1'b0, 1'b0, RST_C);     idle_for(1'b0, 6);
        drv(1'b0, 1'b0, RST_C + 1); idle_for(1'b0, 6);
        // R3/R6: low-speed idle after SE0
        drv(1'b0, 1'b0, 2); idle_for(1'b1, 6);
        drv(1'b1, 1'b0, 3); idle_for(1'b1, 3);
        // R8: keep-alive threshold edges at low speed
        drv(1'b0, 1'b0, KA_C);      idle_for(1'b1, 5);
        drv(1'b0, 1'b0, KA_C + 1);  idle_for(1'b1, 5);
        drv(1'b0, 1'b0, RST_C);     idle_for(1'b1, 5);
        // R9: long SE0 inside a packet
        @(negedge clk); pkt = 1'b1;
        drv(1'b0, 1'b0, RST_C + 10); idle_for(1'b1, 4);
        // R10/R4: preamble inside a packet, full polarity at low rate
        drv(1'b1, 1'b0, 2); pulse_pre(); drv(1'b1, 1'b0, 3); drv(1'b0, 1'b1, 3);
        drv(1'b0, 1'b0, 2); idle_for(1'b0, 4);
        @(negedge clk); pkt = 1'b0;
        drv(1'b0, 1'b0, 2); idle_for(1'b1, 5);
        // R10/R7: preamble held until a bus reset ending in SE1
        pulse_pre(); drv(1'b0, 1'b0, RST_C + 2); drv(1'b1, 1'b1, 4); idle_for(1'b0, 5);
        // fixed modes R5/R6
        cfg = 2'd1; drv(1'b0, 1'b0, 3); idle_for(1'b1, 5);
        cfg = 2'd3; drv(1'b0, 1'b0, 3); idle_for(1'b0, 5);
        cfg = 2'd2; drv(1'b0, 1'b0, 3); idle_for(1'b1, 5);

        // constrained random segments
        for (int s = 0; s < 400; s++) begin
            int kind;
            kind = int'($urandom_range(0, 6));
            case (kind)
                0: idle_for(bit'($urandom_range(0, 1)), int'($urandom_range(1, 20)));
                1: begin
                    int n;
                    n = int'($urandom_range(5, 40));
                    @(negedge clk); pkt = 1'b1;
                    for (int i = 0; i < n; i++) begin
                        bit b;
                        b = bit'($urandom_range(0, 1));
                        @(negedge clk);
                        dp = b; dm = ~b;
                        pre = ($urandom_range(0, 30) == 0);
                    end
                    @(negedge clk); pre = 1'b0;
                    drv(1'b0, 1'b0, 2);
                    idle_for(bit'($urandom_range(0, 1)), 3);
                    @(negedge clk); pkt = 1'b0;
                end
                2, 3: begin
                    int len;
                    case ($urandom_range(0, 7))
                        0: len = KA_C - 1;
                        1: len = KA_C;
                        2: len = KA_C + 1;
                        3: len = RST_C - 1;
                        4: len = RST_C;
                        5: len = RST_C + 1;
                        6: len = RST_C + 20;
                        default: len = int'($urandom_range(1, 10));
                    endcase
                    drv(1'b0, 1'b0, len);
                    idle_for(bit'($urandom_range(0, 1)), int'($urandom_range(2, 8)));
                end
                4: begin
                    @(negedge clk); cfg = 2'($urandom_range(0, 3));
                end
                5: drv(1'b1, 1'b1, int'($urandom_range(1, 4)));
                default: pulse_pre();
            endcase
        end
        idle_for(1'b0, 8);
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule